// File: doc/BRIEF.md
# Timed Fuse and Lock Access Controller

This block sits next to a small processor core and gives software a controlled path to the non-volatile lock and fuse bytes. Software writes a command code into a control register, which arms a lock command for a short window. If the core issues a program-store strobe inside that window, the boot-lock bits are programmed from a data operand. If the core issues a program-load strobe inside its shorter window, the load returns the lock byte, the fuse low byte or the fuse high byte, chosen by a 16-bit pointer. Outside the window, a program-load strobe behaves as an ordinary flash read.

The arm state clears itself in three cases: when a command completes, when the store window runs out, or when software writes any other value to the register. Stored bits are active-low, so a 1 means unprogrammed, and programming can only clear them. While an EEPROM write is busy, control-register writes are refused and armed commands do not take effect.

Top module: `fuse_lock_access`

## Requirements
- R1: After reset the control readback is 0x00, `loadValid` is low, and `bootLockOut` equals bits 5..2 of `LOCK_INIT` (0xF by default).
- R2: A control write whose bits 6..0 equal 0001001 (bit 3 = lock-set, bit 0 = enable; bit 7 is ignored) arms the block. From the next cycle `ctrlRdData` reads 0x09. Any other accepted write value disarms the block and reads back 0x00.
- R3: A store strobe on any of the first four clock edges after the arming write clears each `bootLockOut[i]` for which operand bit i+2 is 0. Operand bits 5..2 map to boot-lock bits 3..0, and the pointer is ignored.
- R4: A load strobe on any of the first three edges after the arming write returns the selected information byte on `loadData`, with `loadValid` high in the cycle after the strobe edge.
- R5: The information byte is selected by pointer. Pointer 0x0000 gives the fuse low byte (0x5E by default), 0x0003 gives the fuse high byte (0xD9 by default), and 0x0001 gives the lock byte {2'b11, bootLockOut[3:0], LOCK_INIT[1:0]}. Any other pointer gives 0xFF.
- R6: An accepted command disarms the block on the edge that takes it. With no command taken, the readback returns to 0x00 after the fourth edge following the arming write.
- R7: A load strobe on the fourth edge or later, or a store strobe on the fifth edge or later, gets no lock or fuse access. The load returns `flashRdData`, and the store leaves `bootLockOut` unchanged.
- R8: A load strobe while the block is disarmed returns `flashRdData` sampled at the strobe edge.
- R9: While `eepromBusy` is high, control writes are ignored. Armed loads return `flashRdData` and armed stores program nothing.
- R10: Programming never sets a boot-lock bit from 0 back to 1.
- R11: An arming write made while the block is already armed restarts the window count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write value |
| ctrlRdData | output | 8 | Control register readback |
| eepromBusy | input | 1 | An EEPROM write is in progress |
| storeStrobe | input | 1 | Program-store instruction strobe |
| loadStrobe | input | 1 | Program-load instruction strobe |
| pointer | input | 16 | Address operand of the load |
| operand | input | 8 | Data operand of the store |
| flashRdData | input | 8 | Normal flash read data |
| loadValid | output | 1 | Load result valid |
| loadData | output | 8 | Load result |
| bootLockOut | output | 4 | Current boot-lock bits, active-low |

## Verification
The hardest cases to reach are the edges of each window. A load must land on exactly the third or the fourth edge after arming, and a store on exactly the fourth or the fifth edge. Arming again mid-window must move both limits. The stimulus therefore counts idle cycles after each arming write before issuing the strobe, and it places a second arming write part-way into an open window. The EEPROM-busy case arms the block first, then raises busy while the window is still open, so that the refused load and store meet a block that is otherwise ready to accept them.

// File: rtl/fuse_lock_pkg.sv
package fuse_lock_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic lockWrite;   // program boot-lock bits from the operand
    logic infoRead;    // return a lock or fuse byte
    logic flashRead;   // return the normal flash read data
  } fl_strobe_t;

  // Control code that arms a lock command: lock-set in bit 3, enable in bit 0.
  localparam logic [6:0] ARM_CODE = 7'b0001001;

  // Pointer addresses of the information bytes.
  localparam logic [15:0] PTR_FUSE_LOW  = 16'h0000;
  localparam logic [15:0] PTR_LOCK      = 16'h0001;
  localparam logic [15:0] PTR_FUSE_HIGH = 16'h0003;

  localparam int BOOT_BITS = 4;

endpackage

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl
  import fuse_lock_pkg::*;
#(
  parameter int STORE_WINDOW = 4,
  parameter int LOAD_WINDOW  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [6:0] ctrlWrCode,
  input  logic       eepromBusy,
  input  logic       storeStrobe,
  input  logic       loadStrobe,
  output fl_strobe_t strobes,
  output logic       armed
);

  localparam int CW = $clog2(STORE_WINDOW + 1);

  logic [CW-1:0] age;
  logic writeTaken;
  logic loadOpen;
  logic storeOpen;
  logic lastCycle;
  logic cmdTaken;

  always_comb begin
    writeTaken        = ctrlWrEn && !eepromBusy;
    loadOpen          = armed && !eepromBusy && (age < CW'(LOAD_WINDOW));
    storeOpen         = armed && !eepromBusy && (age < CW'(STORE_WINDOW));
    lastCycle         = (age == CW'(STORE_WINDOW - 1));
    strobes.lockWrite = storeStrobe && storeOpen;
    strobes.infoRead  = loadStrobe && loadOpen;
    strobes.flashRead = loadStrobe && !loadOpen;
    cmdTaken          = strobes.lockWrite || strobes.infoRead;
  end

  // Arm state and window age. A new write restarts the count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      age   <= '0;
    end else if (writeTaken) begin
      armed <= (ctrlWrCode == ARM_CODE);
      age   <= '0;
    end else if (armed) begin
      if (cmdTaken || lastCycle) begin
        armed <= 1'b0;
        age   <= '0;
      end else begin
        age <= age + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fuse_lock_datapath.sv
module fuse_lock_datapath
  import fuse_lock_pkg::*;
#(
  parameter logic [7:0] FUSE_LOW_INIT  = 8'h5E,
  parameter logic [7:0] FUSE_HIGH_INIT = 8'hD9,
  parameter logic [5:0] LOCK_INIT      = 6'h3F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fl_strobe_t           strobes,
  input  logic [15:0]          pointer,
  input  logic [BOOT_BITS-1:0] lockOperand,
  input  logic [7:0]           flashRdData,
  output logic                 loadValid,
  output logic [7:0]           loadData,
  output logic [BOOT_BITS-1:0] bootLock
);

  logic [7:0] infoByte;
  logic [7:0] lockByte;

  // Each boot-lock bit can only be cleared (programmed).
  for (genvar i = 0; i < BOOT_BITS; i++) begin : g_boot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bootLock[i] <= LOCK_INIT[i+2];
      else if (strobes.lockWrite && !lockOperand[i])
        bootLock[i] <= 1'b0;
    end
  end

  always_comb begin
    lockByte = {2'b11, bootLock, LOCK_INIT[1:0]};
    case (pointer)
      PTR_FUSE_LOW:  infoByte = FUSE_LOW_INIT;
      PTR_LOCK:      infoByte = lockByte;
      PTR_FUSE_HIGH: infoByte = FUSE_HIGH_INIT;
      default:       infoByte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadData  <= 8'h00;
    end else begin
      loadValid <= strobes.infoRead || strobes.flashRead;
      if (strobes.infoRead)
        loadData <= infoByte;
      else if (strobes.flashRead)
        loadData <= flashRdData;
    end
  end

endmodule

// File: rtl/fuse_lock_access.sv
module fuse_lock_access
  import fuse_lock_pkg::*;
#(
  parameter int          STORE_WINDOW   = 4,
  parameter int          LOAD_WINDOW    = 3,
  parameter logic [7:0]  FUSE_LOW_INIT  = 8'h5E,
  parameter logic [7:0]  FUSE_HIGH_INIT = 8'hD9,
  parameter logic [5:0]  LOCK_INIT      = 6'h3F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [7:0]  ctrlWrData,
  output logic [7:0]  ctrlRdData,
  input  logic        eepromBusy,
  input  logic        storeStrobe,
  input  logic        loadStrobe,
  input  logic [15:0] pointer,
  input  logic [7:0]  operand,
  input  logic [7:0]  flashRdData,
  output logic        loadValid,
  output logic [7:0]  loadData,
  output logic [3:0]  bootLockOut
);

  fl_strobe_t strobes;
  logic       armed;
  logic       unusedBits;

  assign unusedBits = ^{ctrlWrData[7], operand[7:6], operand[1:0]};
  assign ctrlRdData = {4'b0000, armed, 2'b00, armed};

  fuse_lock_ctrl #(
    .STORE_WINDOW(STORE_WINDOW),
    .LOAD_WINDOW (LOAD_WINDOW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrCode (ctrlWrData[6:0]),
    .eepromBusy (eepromBusy),
    .storeStrobe(storeStrobe),
    .loadStrobe (loadStrobe),
    .strobes    (strobes),
    .armed      (armed)
  );

  fuse_lock_datapath #(
    .FUSE_LOW_INIT (FUSE_LOW_INIT),
    .FUSE_HIGH_INIT(FUSE_HIGH_INIT),
    .LOCK_INIT     (LOCK_INIT)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pointer    (pointer),
    .lockOperand(operand[5:2]),
    .flashRdData(flashRdData),
    .loadValid  (loadValid),
    .loadData   (loadData),
    .bootLock   (bootLockOut)
  );

endmodule

// File: rtl/fuse_lock_access_chk.sv
module fuse_lock_access_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWrEn,
  input logic [7:0] ctrlWrData,
  input logic [7:0] ctrlRdData,
  input logic       eepromBusy,
  input logic       storeStrobe,
  input logic       loadStrobe,
  input logic [7:0] flashRdData,
  input logic       loadValid,
  input logic [7:0] loadData,
  input logic [3:0] bootLockOut
);

  // Consecutive armed cycles since the last accepted control write.
  logic [2:0] armAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      armAge <= '0;
    else if (ctrlWrEn && !eepromBusy)
      armAge <= '0;
    else if (ctrlRdData != 8'h00 && armAge != 3'd7)
      armAge <= armAge + 1'b1;
    else
      armAge <= '0;
  end

  assert_arm_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !eepromBusy && ctrlWrData[6:0] == 7'b0001001) |=> (ctrlRdData == 8'h09));

  assert_load_answers_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> loadValid);

  assert_window_expires_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData != 8'h00) |-> (armAge < 3'd4));

  assert_disarmed_flash_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && ctrlRdData == 8'h00) |=> (loadData == $past(flashRdData)));

  assert_busy_no_program_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eepromBusy && storeStrobe) |=> $stable(bootLockOut));

  assert_only_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((bootLockOut & ~$past(bootLockOut)) == 4'b0000));

endmodule

bind fuse_lock_access fuse_lock_access_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWrEn   (ctrlWrEn),
  .ctrlWrData (ctrlWrData),
  .ctrlRdData (ctrlRdData),
  .eepromBusy (eepromBusy),
  .storeStrobe(storeStrobe),
  .loadStrobe (loadStrobe),
  .flashRdData(flashRdData),
  .loadValid  (loadValid),
  .loadData   (loadData),
  .bootLockOut(bootLockOut)
);

// File: tb/fuse_lock_access_tb.sv
module fuse_lock_access_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = 8'h00;
  logic [7:0]  ctrlRdData;
  logic        eepromBusy = 1'b0;
  logic        storeStrobe = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [15:0] pointer = 16'h0000;
  logic [7:0]  operand = 8'hFF;
  logic [7:0]  flashRdData = 8'hA5;
  logic        loadValid;
  logic [7:0]  loadData;
  logic [3:0]  bootLockOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      reqQ[$];

  always #4 clk = ~clk;

  fuse_lock_access u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .eepromBusy(eepromBusy), .storeStrobe(storeStrobe),
    .loadStrobe(loadStrobe), .pointer(pointer), .operand(operand),
    .flashRdData(flashRdData), .loadValid(loadValid), .loadData(loadData),
    .bootLockOut(bootLockOut)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic doLoad(input logic [15:0] p, input logic [7:0] exp, input string req);
    pointer = p; loadStrobe = 1'b1;
    expQ.push_back(exp); reqQ.push_back(req);
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic doStore(input logic [7:0] op, input logic [15:0] p);
    operand = op; pointer = p; storeStrobe = 1'b1;
    @(negedge clk);
    storeStrobe = 1'b0;
  endtask

  // Monitor: pops expected load results as they appear.
  always @(negedge clk) begin
    if (rstN && loadValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: actual unexpected load 0x%02h expected none", loadData);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        check8(r, loadData, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    check8("R1 ctrl", ctrlRdData, 8'h00);
    check8("R1 valid", {7'b0, loadValid}, 8'h00);
    check8("R1 lock", {4'b0, bootLockOut}, 8'h0F);

    doLoad(16'h0001, 8'hA5, "R8 disarmed load");

    doWrite(8'h89);
    check8("R2 arm bit7 ignored", ctrlRdData, 8'h09);
    doLoad(16'h0000, 8'h5E, "R4 R5 fuse low k1");
    check8("R6 clear on completion", ctrlRdData, 8'h00);

    doWrite(8'h09); idle(2);
    doLoad(16'h0003, 8'hD9, "R4 R5 fuse high k3");

    doWrite(8'h09); idle(3);
    doLoad(16'h0001, 8'hA5, "R7 late load k4");
    check8("R6 cleared after store window", ctrlRdData, 8'h00);

    doWrite(8'h09); idle(3);
    check8("R6 still armed edge3", ctrlRdData, 8'h09);
    idle(1);
    check8("R6 expired edge4", ctrlRdData, 8'h00);

    doWrite(8'h09);
    doLoad(16'h0007, 8'hFF, "R5 undefined pointer 7");
    doWrite(8'h09);
    doLoad(16'h0002, 8'hFF, "R5 undefined pointer 2");

    doWrite(8'h09); idle(3);
    doStore(8'hEF, 16'h1234);
    check8("R3 store k4", {4'b0, bootLockOut}, 8'h0B);
    check8("R6 clear after store", ctrlRdData, 8'h00);

    doWrite(8'h09);
    doLoad(16'h0001, 8'hEF, "R5 lock byte");

    doWrite(8'h09); idle(4);
    doStore(8'h00, 16'h0001);
    check8("R7 late store k5", {4'b0, bootLockOut}, 8'h0B);

    doWrite(8'h09);
    doStore(8'h37, 16'h0000);
    check8("R10 no bit set", {4'b0, bootLockOut}, 8'h09);

    doWrite(8'h09); idle(2);
    doWrite(8'h09); idle(2);
    doLoad(16'h0000, 8'h5E, "R11 rearm restarts window");

    doWrite(8'h09);
    doWrite(8'h01);
    check8("R2 other code disarms", ctrlRdData, 8'h00);

    eepromBusy = 1'b1;
    doWrite(8'h09);
    check8("R9 write ignored when busy", ctrlRdData, 8'h00);
    eepromBusy = 1'b0;
    doWrite(8'h09);
    eepromBusy = 1'b1;
    doLoad(16'h0000, 8'hA5, "R9 busy load gets flash");
    doStore(8'h00, 16'h0000);
    check8("R9 busy store no program", {4'b0, bootLockOut}, 8'h09);
    eepromBusy = 1'b0;
    idle(3);
    check8("R6 cleared after busy window", ctrlRdData, 8'h00);

    idle(2);
    check8("R4 queue drained", 8'(expQ.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule